// File: doc/BRIEF.md
# Serial Command Word Validator

This block receives a 24-bit command word serially, one bit per strobe, and decides whether the word is a legal request for this particular token on a shared bus. An opening byte selects a read or a write. Two mode bits then select a normal transfer or a programming transfer. Thirteen bits must then equal this token's group code, and a closing bit must be a one. After the 24th bit, the block raises a done flag together with one of four verdicts: read, write, program or abort.

A separate reject flag rises as soon as any bit departs from every legal pattern. It then stays high until reset. The verdict is still published only after all 24 bits. The group code is a parameter, so several instances can sit on the same serial line, and each one accepts only words that carry its own code. An active-low reset clears the bit count and the reject flag, and that starts a new word. Strobes that arrive after the 24th bit are ignored.

Top module: `cmdw_checker`

## Requirements
- R1: After reset, `done` is 0, `reject` is 0 and `verdict` is 2'b00.
- R2: Bit positions count from 0 in arrival order. An opening byte of 0,1,1,0,0,0,1,0 (positions 0 to 7), followed by valid remaining fields and mode bits 1,0, gives verdict 2'b01 (read).
- R3: An opening byte of 1,0,0,1,1,1,0,1, followed by valid remaining fields and mode bits 1,0, gives verdict 2'b10 (write).
- R4: Mode bits sit at positions 8 and 9. The pair 0,1 selects program, which gives verdict 2'b11 with the write opcode. The pair 1,0 selects normal. The pairs 0,0 and 1,1 abort.
- R5: Program mode combined with the read opcode aborts, and `reject` rises after position 9.
- R6: Positions 10 to 22 must equal parameter `GROUP_CODE`, with bit 12 first and bit 0 last. Any difference aborts.
- R7: Position 23 must be 1. A 0 there aborts.
- R8: `done` rises after the edge that takes the 24th strobe, and not before. After that, `done` and `verdict` hold, and further strobes change neither until reset.
- R9: `reject` rises after the edge that takes the first offending bit, and it stays high until reset. If the word ends with `reject` high, the verdict is 2'b00 (abort).
- R10: Any opening byte other than the two opcodes aborts, with `reject` rising at the first position where the byte leaves the opcode chosen by its first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset; starts a new word |
| bit_stb | input | 1 | Strobe; one command bit is taken per edge while high |
| bit_in | input | 1 | Serial command bit |
| done | output | 1 | High once 24 bits have been taken |
| verdict | output | 2 | 00 abort, 01 read, 10 write, 11 program; 00 while `done` is low |
| reject | output | 1 | Sticky flag: a bit has already broken the word |

## Verification
The bench attacks the boundaries of each field. It flips the last opcode bit, the last group-code bit and the stop bit. A design that mis-indexed a field would either accept these words or reject them at the wrong position, and the per-bit check of `reject` catches the wrong position. The bench sends both illegal mode pairs, and it sends program mode with the read opcode, a combination that a design checking the mode bits alone would accept as program. Strobes after the 24th bit, and a reset in the middle of a word, expose a counter that wraps or keeps stale reject state.

// File: rtl/cmdw_pkg.sv
package cmdw_pkg;
  localparam int CMD_BITS  = 24;
  localparam int POS_W     = 5;
  localparam int OP_BITS   = 8;
  localparam int GRP_BITS  = 13;
  localparam int MODE0_POS = OP_BITS;
  localparam int MODE1_POS = OP_BITS + 1;
  localparam int GRP_FIRST = OP_BITS + 2;
  localparam int GRP_LAST  = GRP_FIRST + GRP_BITS - 1;
  localparam int STOP_POS  = CMD_BITS - 1;

  localparam logic [OP_BITS-1:0] RD_OPCODE = 8'b0110_0010;
  localparam logic [OP_BITS-1:0] WR_OPCODE = 8'b1001_1101;

  typedef enum logic [1:0] {
    V_ABORT = 2'b00,
    V_READ  = 2'b01,
    V_WRITE = 2'b10,
    V_PROG  = 2'b11
  } verdict_e;

  typedef enum logic [2:0] {
    F_OP, F_MODE0, F_MODE1, F_GROUP, F_STOP, F_NONE
  } field_e;

  function automatic field_e field_of(input logic [POS_W-1:0] pos);
    int p;
    p = int'(pos);
    if (p < OP_BITS)        return F_OP;
    else if (p == MODE0_POS) return F_MODE0;
    else if (p == MODE1_POS) return F_MODE1;
    else if (p <= GRP_LAST)  return F_GROUP;
    else if (p == STOP_POS)  return F_STOP;
    else                     return F_NONE;
  endfunction

  // Opcode patterns are written first-arrived bit on the left (MSB).
  function automatic logic op_bit(input logic [OP_BITS-1:0] pat,
                                  input logic [POS_W-1:0] pos);
    int k;
    k = OP_BITS - 1 - int'(pos);
    if (k < 0 || k >= OP_BITS) return 1'b0;
    return pat[k[2:0]];
  endfunction

  // Group code arrives MSB first.
  function automatic logic group_bit(input logic [GRP_BITS-1:0] code,
                                     input logic [POS_W-1:0] pos);
    int k;
    k = GRP_LAST - int'(pos);
    if (k < 0 || k >= GRP_BITS) return 1'b0;
    return code[k[3:0]];
  endfunction

  function automatic verdict_e verdict_of(input logic rej, input logic prog,
                                          input logic rd);
    if (rej)       return V_ABORT;
    else if (prog) return V_PROG;
    else if (rd)   return V_READ;
    else           return V_WRITE;
  endfunction
endpackage

// File: rtl/cmdw_counter.sv
module cmdw_counter
  import cmdw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stb,
  output logic [POS_W-1:0] pos,
  output logic             full,
  output logic             take
);
  localparam logic [POS_W-1:0] LAST = POS_W'(CMD_BITS);

  assign full = (pos == LAST);
  assign take = stb && !full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pos <= '0;
    else if (take) pos <= pos + 1'b1;
  end

  // R8
  pos_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pos <= LAST);
  // R8
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |=> full && $stable(pos));
endmodule

// File: rtl/cmdw_matcher.sv
module cmdw_matcher
  import cmdw_pkg::*;
#(
  parameter logic [GRP_BITS-1:0] GROUP_CODE = 13'b1_0110_0101_1010
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [POS_W-1:0] pos,
  input  logic             bit_in,
  output logic             rd_live,
  output logic             wr_live,
  output logic             prog_sel,
  output logic             reject
);
  field_e fld;
  logic   rd_hit, wr_hit, mode0, is_prog, is_norm, bit_bad;

  assign fld     = field_of(pos);
  assign rd_hit  = rd_live && (bit_in == op_bit(RD_OPCODE, pos));
  assign wr_hit  = wr_live && (bit_in == op_bit(WR_OPCODE, pos));
  assign is_prog = !mode0 && bit_in;
  assign is_norm = mode0 && !bit_in;

  always_comb begin
    bit_bad = 1'b0;
    if (take) begin
      case (fld)
        F_OP:    bit_bad = !rd_hit && !wr_hit;
        F_MODE1: bit_bad = !(is_prog || is_norm) || (is_prog && rd_live);
        F_GROUP: bit_bad = (bit_in != group_bit(GROUP_CODE, pos));
        F_STOP:  bit_bad = !bit_in;
        default: bit_bad = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_live  <= 1'b1;
      wr_live  <= 1'b1;
      mode0    <= 1'b0;
      prog_sel <= 1'b0;
      reject   <= 1'b0;
    end else begin
      if (take && fld == F_OP) begin
        rd_live <= rd_hit;
        wr_live <= wr_hit;
      end
      if (take && fld == F_MODE0) mode0 <= bit_in;
      if (take && fld == F_MODE1) prog_sel <= is_prog;
      if (bit_bad) reject <= 1'b1;
    end
  end

  // R9
  reject_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> reject);
  // R9
  bad_bit_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_bad |=> reject);
  // R5
  prog_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_sel && !reject) |-> (wr_live && !rd_live));
  // R10
  one_opcode_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pos != '0) |-> !(rd_live && wr_live));
endmodule

// File: rtl/cmdw_checker.sv
module cmdw_checker
  import cmdw_pkg::*;
#(
  parameter logic [GRP_BITS-1:0] GROUP_CODE = 13'b1_0110_0101_1010
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_stb,
  input  logic       bit_in,
  output logic       done,
  output logic [1:0] verdict,
  output logic       reject
);
  logic [POS_W-1:0] pos;
  logic             take, rd_live, wr_live, prog_sel;

  cmdw_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .stb(bit_stb),
    .pos(pos), .full(done), .take(take)
  );

  cmdw_matcher #(.GROUP_CODE(GROUP_CODE)) u_match (
    .clk(clk), .rst_n(rst_n), .take(take), .pos(pos), .bit_in(bit_in),
    .rd_live(rd_live), .wr_live(wr_live), .prog_sel(prog_sel),
    .reject(reject)
  );

  assign verdict = done ? verdict_of(reject, prog_sel, rd_live) : V_ABORT;

  // R8
  verdict_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done && $stable(verdict));
  // R9
  reject_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && reject) |-> verdict == V_ABORT);
  // R4
  accept_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !reject) |-> verdict != V_ABORT);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> verdict == V_ABORT);
endmodule

// File: tb/test_cmdw_checker.sv
`timescale 1ns/1ps
module test_cmdw_checker;
  localparam logic [12:0] GRP = 13'b1_0110_0101_1010;
  localparam logic [7:0]  RD  = 8'b0110_0010;
  localparam logic [7:0]  WR  = 8'b1001_1101;

  logic clk = 1'b0, rst_n = 1'b0, bit_stb = 1'b0, bit_in = 1'b0;
  logic done, reject;
  logic [1:0] verdict;
  int nchk = 0, nfail = 0;
  logic [1:0] expq[$];
  string tagq[$];
  bit mon_seen = 1'b0;

  always #2.5 clk = ~clk;

  cmdw_checker #(.GROUP_CODE(GRP)) i_cmdw_checker (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .bit_in(bit_in),
    .done(done), .verdict(verdict), .reject(reject)
  );

  task automatic check(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Word layout: w[23] is the first bit sent.
  function automatic logic [23:0] mk(input logic [7:0] op, input logic m0,
                                     input logic m1, input logic [12:0] g,
                                     input logic stop);
    return {op, m0, m1, g, stop};
  endfunction

  // Independent model: first failing position (-1 if none) and verdict.
  function automatic int first_fail(input logic [23:0] w);
    logic [7:0] cand;
    cand = w[23] ? WR : RD;
    for (int i = 0; i < 8; i++) if (w[23-i] != cand[7-i]) return i;
    if (w[15] == w[14]) return 9;
    if (!w[15] && w[14] && cand == RD) return 9;
    for (int i = 0; i < 13; i++) if (w[13-i] != GRP[12-i]) return 10 + i;
    if (!w[0]) return 23;
    return -1;
  endfunction

  function automatic logic [1:0] model(input logic [23:0] w);
    if (first_fail(w) >= 0) return 2'b00;
    if (!w[15] && w[14]) return 2'b11;
    return (w[23:16] == RD) ? 2'b01 : 2'b10;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bit_stb = 1'b0;
    @(negedge clk);
    mon_seen = 1'b0;
    rst_n = 1'b1;
  endtask

  // Driver: sends nb bits, checks reject/done after each, pushes the verdict.
  task automatic send(input string tag, input logic [23:0] w, input int nb);
    int ff;
    ff = first_fail(w);
    if (nb == 24) begin expq.push_back(model(w)); tagq.push_back(tag); end
    for (int i = 0; i < nb; i++) begin
      bit_stb = 1'b1; bit_in = w[23-i];
      @(negedge clk);
      check({tag, " R9 reject"}, reject, (ff >= 0 && i >= ff) ? 1 : 0);
      check({tag, " R8 done"}, done, (i == 23) ? 1 : 0);
    end
    bit_stb = 1'b0;
    @(negedge clk);
  endtask

  // Monitor: pops the expected verdict when done first appears.
  always @(negedge clk) begin
    if (rst_n && done && !mon_seen) begin
      mon_seen = 1'b1;
      if (expq.size() == 0) check("R8 unexpected done", 1, 0);
      else check(tagq.pop_front(), verdict, expq.pop_front());
    end
  end

  initial begin
    #100000;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    check("R1 done", done, 0);
    check("R1 reject", reject, 0);
    check("R1 verdict", verdict, 0);
    rst_n = 1'b1;

    send("R2 read", mk(RD, 1, 0, GRP, 1), 24);
    do_reset();
    send("R3 write", mk(WR, 1, 0, GRP, 1), 24);
    // R8: extra strobes ignored
    for (int i = 0; i < 5; i++) begin
      bit_stb = 1'b1; bit_in = i[0];
      @(negedge clk);
    end
    bit_stb = 1'b0;
    check("R8 held done", done, 1);
    check("R8 held verdict", verdict, 2);
    check("R8 held reject", reject, 0);
    do_reset();
    send("R4 program", mk(WR, 0, 1, GRP, 1), 24);
    do_reset();
    send("R4 mode 00", mk(WR, 0, 0, GRP, 1), 24);
    do_reset();
    send("R4 mode 11", mk(RD, 1, 1, GRP, 1), 24);
    do_reset();
    send("R5 program read", mk(RD, 0, 1, GRP, 1), 24);
    do_reset();
    send("R6 group last bit", mk(WR, 1, 0, GRP ^ 13'h1, 1), 24);
    do_reset();
    send("R6 group first bit", mk(RD, 1, 0, GRP ^ 13'h1000, 1), 24);
    do_reset();
    send("R7 stop zero", mk(RD, 1, 0, GRP, 0), 24);
    do_reset();
    send("R10 op last bit", mk(8'b0110_0011, 1, 0, GRP, 1), 24);
    do_reset();
    send("R10 op all ones", mk(8'hFF, 1, 0, GRP, 1), 24);
    do_reset();
    // R9: reset mid-word clears reject, then a clean read
    send("R9 partial", mk(8'h00, 1, 0, GRP, 1), 10);
    do_reset();
    check("R9 reject cleared", reject, 0);
    check("R1 done cleared", done, 0);
    send("R2 after reset", mk(RD, 1, 0, GRP, 1), 24);
    @(negedge clk);
    check("R8 queue drained", expq.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule